// File: doc/BRIEF.md
# Word-Wide Access Port for Byte Buffer Memories

This block sits between a microprocessor bus and three byte-organised buffer memories. The processor writes one command code that picks a buffer and a direction. It then makes as many 16-bit data accesses as it needs. Each access moves two bytes and advances an internal byte pointer by two. A transfer count is latched with the command. When the pointer reaches that count, the block raises an end-of-transfer event. The event sets a sticky interrupt bit and marks the target buffer full or empty.

Two of the buffers form a ping-pong pair for isochronous traffic. At any time one half faces the processor and the other faces the bus controller. The halves change places on every frame-start pulse, but only while at least one of them is not full. When both halves are full, a frame start leaves the processor on half 1. The third buffer holds asynchronous traffic and never swaps.

Top module: `bytebuf_port`

## Requirements
- R1: Command codes 0x40 and 0xC0 select a read and a write of the isochronous half that faces the processor. Codes 0x41 and 0xC1 select a read and a write of the asynchronous buffer. Any other code on `cmd_wr` changes neither the mode nor the pointer, and the transfer already in progress continues.
- R2: A valid command resets the byte pointer to 0 and latches `xfer_cnt`. One command serves any number of following data accesses.
- R3: A data access moves `wr_data[7:0]` to or from the even byte address at the pointer and `wr_data[15:8]` to or from the next odd address. For reads, `rd_data` carries the same mapping: the word at the current pointer appears combinationally while `dat_rd` is high.
- R4: Each accepted access advances the byte pointer by 2. Accesses of the wrong direction for the current mode are ignored.
- R5: The access that brings the pointer equal to the latched count sets `int_flags[2]` at that same clock edge. All other `int_flags` bits stay 0.
- R6: `int_flags[2]` holds until a cycle with `int_clr[2]`=1 clears it. A new set in the same cycle as a clear wins.
- R7: Once the pointer has reached the count, data accesses are ignored and `rd_data` reads 0x0000. A count of 0 is complete at once and raises no event.
- R8: An odd count is rounded up to the next even value. The high byte of the final write is then not stored.
- R9: A write end-of-transfer sets the full flag of its buffer (`iso_full[iso_half]` or `async_full`). A read end-of-transfer clears that flag. `ctl_release[0]`, `ctl_release[1]` and `ctl_release[2]` clear the flags of iso half 0, iso half 1 and the asynchronous buffer.
- R10: On `sof`, `iso_half` toggles unless both `iso_full` bits are 1. In that case `iso_half` becomes 1.
- R11: After reset, `int_flags`, `iso_full`, `async_full` and `iso_half` are 0, and `rd_data` is 0x0000.
- R12: A count larger than the buffer depth is treated as the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| xfer_cnt | input | AW+1 | Transfer byte count, latched with a valid command |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| wr_data | input | DATA_W | Write word |
| rd_data | output | DATA_W | Read word at the current pointer |
| int_clr | input | 8 | Write-one-to-clear mask for `int_flags` |
| int_flags | output | 8 | Interrupt flags, bit 2 is end of transfer |
| sof | input | 1 | Frame-start pulse |
| ctl_release | input | 3 | Controller-side release of buffer full flags |
| iso_half | output | 1 | Isochronous half that faces the processor |
| iso_full | output | 2 | Full flags of isochronous halves 0 and 1 |
| async_full | output | 1 | Full flag of the asynchronous buffer |

## Verification
The port is driven with whole-word write and read-back sequences, and the reads are matched against a queue of expected words. An odd count is tried after a known pattern has been stored, so that the one preserved byte shows both the lane order and the discarded final high byte. Several cases show that an access was ignored rather than executed: an unknown code in the middle of a transfer, a write in read mode, accesses past the count, and a zero count. Frame-start pulses are applied with zero, one and two halves full. The data read from each half then shows whether the swap and the hold-on-half-1 behaviour steered accesses to the right memory.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
   typedef enum logic [2:0] {
      M_IDLE,
      M_ISO_RD,
      M_ISO_WR,
      M_ASY_RD,
      M_ASY_WR
   } port_mode_e;

   localparam logic [7:0] CMD_ISO_RD = 8'h40;
   localparam logic [7:0] CMD_ISO_WR = 8'hC0;
   localparam logic [7:0] CMD_ASY_RD = 8'h41;
   localparam logic [7:0] CMD_ASY_WR = 8'hC1;

   localparam int INT_W   = 8;
   localparam int EOT_BIT = 2;
   localparam int NBANK   = 3;
endpackage

// File: rtl/bbp_cmd_dec.sv
module bbp_cmd_dec
   import bbp_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [7:0] cmd_code,
   output logic       cmd_valid,
   output port_mode_e cmd_mode
);
   always_comb begin
      cmd_valid = 1'b0;
      cmd_mode  = M_IDLE;
      if (cmd_wr) begin
         unique case (cmd_code)
            CMD_ISO_RD: begin cmd_valid = 1'b1; cmd_mode = M_ISO_RD; end
            CMD_ISO_WR: begin cmd_valid = 1'b1; cmd_mode = M_ISO_WR; end
            CMD_ASY_RD: begin cmd_valid = 1'b1; cmd_mode = M_ASY_RD; end
            CMD_ASY_WR: begin cmd_valid = 1'b1; cmd_mode = M_ASY_WR; end
            default:    begin cmd_valid = 1'b0; cmd_mode = M_IDLE;   end
         endcase
      end
   end
endmodule

// File: rtl/bbp_byte_ram.sv
module bbp_byte_ram #(
   parameter int DEPTH = 256,
   parameter int LANES = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic [LANES-1:0]   we,
   input  logic [AW-1:0]      addr,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (we[l]) mem[addr + AW'(l)] <= wdata[8*l +: 8];
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rdata[8*l +: 8] = mem[addr + AW'(l)];
   end
endmodule

// File: rtl/bbp_xfer_ptr.sv
module bbp_xfer_ptr #(
   parameter int DEPTH = 256,
   parameter int LANES = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1,
   localparam int LSH  = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PW-1:0]    cnt_in,
   input  logic             step,
   output logic [PW-1:0]    ptr_q,
   output logic [PW-1:0]    lim_q,
   output logic [LANES-1:0] lane_en,
   output logic             done,
   output logic             eot
);
   logic [PW-1:0] raw_c, lim_c, raw_q;
   logic [PW:0]   up_c;

   always_comb begin
      raw_c = (cnt_in > PW'(DEPTH)) ? PW'(DEPTH) : cnt_in;
      up_c  = {1'b0, raw_c} + (PW+1)'(LANES - 1);
      lim_c = PW'((up_c >> LSH) << LSH);
   end

   assign done = (ptr_q >= lim_q);
   assign eot  = step && ((ptr_q + PW'(LANES)) == lim_q);

   for (genvar l = 0; l < LANES; l++) begin : g_en
      assign lane_en[l] = (ptr_q + PW'(l)) < raw_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         lim_q <= '0;
         raw_q <= '0;
      end else if (load) begin
         ptr_q <= '0;
         lim_q <= lim_c;
         raw_q <= raw_c;
      end else if (step) begin
         ptr_q <= ptr_q + PW'(LANES);
      end
   end
endmodule

// File: rtl/bbp_pingpong.sv
module bbp_pingpong (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof,
   input  logic       eot,
   input  logic       eot_wr,
   input  logic       eot_iso,
   input  logic [2:0] ctl_release,
   output logic       iso_half,
   output logic [1:0] iso_full,
   output logic       async_full
);
   logic [1:0] iso_full_n;
   logic       async_full_n;
   logic       half_n;

   always_comb begin
      iso_full_n   = iso_full & ~ctl_release[1:0];
      async_full_n = async_full & ~ctl_release[2];
      if (eot && eot_iso)  iso_full_n[iso_half] = eot_wr;
      if (eot && !eot_iso) async_full_n = eot_wr;
      half_n = iso_half;
      if (sof) half_n = (&iso_full) ? 1'b1 : ~iso_half;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iso_half   <= 1'b0;
         iso_full   <= '0;
         async_full <= 1'b0;
      end else begin
         iso_half   <= half_n;
         iso_full   <= iso_full_n;
         async_full <= async_full_n;
      end
   end
endmodule

// File: rtl/bytebuf_port.sv
module bytebuf_port
   import bbp_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_code,
   input  logic [PW-1:0]     xfer_cnt,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [INT_W-1:0]  int_clr,
   output logic [INT_W-1:0]  int_flags,
   input  logic              sof,
   input  logic [2:0]        ctl_release,
   output logic              iso_half,
   output logic [1:0]        iso_full,
   output logic              async_full
);
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("bytebuf_port: DATA_W must be a multiple of 8");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("bytebuf_port: DATA_W/8 must be a power of two");
   end
   if ((1 << AW) != DEPTH || DEPTH < LANES) begin : g_bad_depth
      $error("bytebuf_port: DEPTH must be a power of two not below DATA_W/8");
   end

   port_mode_e        mode_q, cmd_mode;
   logic              cmd_valid;
   logic              is_wr, is_rd, is_iso;
   logic              step, done, eot;
   logic [PW-1:0]     ptr_q, lim_q;
   logic [LANES-1:0]  lane_en;
   logic [1:0]        bank_sel;
   logic [DATA_W-1:0] bank_rd [NBANK];

   bbp_cmd_dec u_dec (
      .cmd_wr    (cmd_wr),
      .cmd_code  (cmd_code),
      .cmd_valid (cmd_valid),
      .cmd_mode  (cmd_mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         mode_q <= M_IDLE;
      else if (cmd_valid) mode_q <= cmd_mode;
   end

   assign is_wr  = (mode_q == M_ISO_WR) || (mode_q == M_ASY_WR);
   assign is_rd  = (mode_q == M_ISO_RD) || (mode_q == M_ASY_RD);
   assign is_iso = (mode_q == M_ISO_WR) || (mode_q == M_ISO_RD);
   assign step   = !cmd_wr && !done && ((is_wr && dat_wr) || (is_rd && dat_rd));

   bbp_xfer_ptr #(.DEPTH(DEPTH), .LANES(LANES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_valid),
      .cnt_in  (xfer_cnt),
      .step    (step),
      .ptr_q   (ptr_q),
      .lim_q   (lim_q),
      .lane_en (lane_en),
      .done    (done),
      .eot     (eot)
   );

   assign bank_sel = is_iso ? {1'b0, iso_half} : 2'd2;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [LANES-1:0] bank_we;
      assign bank_we = (step && is_wr && bank_sel == 2'(b)) ? lane_en : '0;
      bbp_byte_ram #(.DEPTH(DEPTH), .LANES(LANES)) u_ram (
         .clk   (clk),
         .we    (bank_we),
         .addr  (ptr_q[AW-1:0]),
         .wdata (wr_data),
         .rdata (bank_rd[b])
      );
   end

   assign rd_data = (is_rd && !done) ? bank_rd[bank_sel] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_flags <= '0;
      end else begin
         if (int_clr[EOT_BIT]) int_flags[EOT_BIT] <= 1'b0;
         if (eot)              int_flags[EOT_BIT] <= 1'b1;
      end
   end

   bbp_pingpong u_pp (
      .clk         (clk),
      .rst_n       (rst_n),
      .sof         (sof),
      .eot         (eot),
      .eot_wr      (is_wr),
      .eot_iso     (is_iso),
      .ctl_release (ctl_release),
      .iso_half    (iso_half),
      .iso_full    (iso_full),
      .async_full  (async_full)
   );
endmodule

// File: rtl/bbp_chk.sv
module bbp_chk #(
   parameter int PW = 9,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_wr,
   input logic [7:0]    cmd_code,
   input logic [DW-1:0] rd_data,
   input logic [7:0]    int_flags,
   input logic [7:0]    int_clr,
   input logic          sof,
   input logic          iso_half,
   input logic [1:0]    iso_full,
   input logic [PW-1:0] ptr_q,
   input logic [PW-1:0] lim_q
);
   a_r2_cmd_zeroes_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (cmd_code == 8'h40 || cmd_code == 8'hC0 ||
                  cmd_code == 8'h41 || cmd_code == 8'hC1)) |=> (ptr_q == '0));

   a_r5_flag_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flags[2]) |-> (ptr_q == lim_q));

   a_r5_other_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int_flags[7:3] == '0) && (int_flags[1:0] == '0));

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (int_flags[2] && !int_clr[2]) |=> int_flags[2]);

   a_r7_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= lim_q);

   a_r7_rd_zero_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q >= lim_q) |-> (rd_data == '0));

   a_r10_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && iso_full != 2'b11) |=> (iso_half != $past(iso_half)));

   a_r10_hold_half1: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && iso_full == 2'b11) |=> iso_half);
endmodule

bind bytebuf_port bbp_chk #(.PW(PW), .DW(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_code  (cmd_code),
   .rd_data   (rd_data),
   .int_flags (int_flags),
   .int_clr   (int_clr),
   .sof       (sof),
   .iso_half  (iso_half),
   .iso_full  (iso_full),
   .ptr_q     (ptr_q),
   .lim_q     (lim_q)
);

// File: tb/tb_bytebuf_port.sv
module tb_bytebuf_port;
   localparam int DEPTH = 256;
   localparam int PW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [7:0]    cmd_code = '0;
   logic [PW-1:0] xfer_cnt = '0;
   logic          dat_wr = 1'b0;
   logic          dat_rd = 1'b0;
   logic [15:0]   wr_data = '0;
   logic [15:0]   rd_data;
   logic [7:0]    int_clr = '0;
   logic [7:0]    int_flags;
   logic          sof = 1'b0;
   logic [2:0]    ctl_release = '0;
   logic          iso_half;
   logic [1:0]    iso_full;
   logic          async_full;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   bytebuf_port #(.DEPTH(DEPTH), .DATA_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
      .xfer_cnt(xfer_cnt), .dat_wr(dat_wr), .dat_rd(dat_rd),
      .wr_data(wr_data), .rd_data(rd_data), .int_clr(int_clr),
      .int_flags(int_flags), .sof(sof), .ctl_release(ctl_release),
      .iso_half(iso_half), .iso_full(iso_full), .async_full(async_full)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [7:0] c, input int n);
      cmd_wr = 1'b1; cmd_code = c; xfer_cnt = PW'(n);
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic do_wr(input logic [15:0] w);
      dat_wr = 1'b1; wr_data = w;
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [15:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      dat_rd = 1'b1;
      @(negedge clk);
      dat_rd = 1'b0;
   endtask

   task automatic do_clr();
      int_clr = 8'h04;
      @(negedge clk);
      int_clr = '0;
   endtask

   task automatic do_sof();
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
   endtask

   // scoreboard monitor: compares each read word against the queue
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (dat_rd) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R3: actual %h expected none (unexpected read)", rd_data);
            end else begin
               check(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 int_flags", 32'(int_flags), 0);
      check("R11 iso_full", 32'(iso_full), 0);
      check("R11 async_full", 32'(async_full), 0);
      check("R11 iso_half", 32'(iso_half), 0);
      check("R11 rd_data", 32'(rd_data), 0);

      // R1 R2 R4 R5 async write of five words
      do_cmd(8'hC1, 10);
      do_wr(16'h1100); do_wr(16'h3322); do_wr(16'h5544); do_wr(16'h7766);
      check("R5 no event before count", 32'(int_flags), 0);
      do_wr(16'h9988);
      check("R5 event at count", 32'(int_flags), 32'h04);
      check("R9 async full after write", 32'(async_full), 1);
      @(negedge clk);
      check("R6 flag sticky", 32'(int_flags), 32'h04);
      do_clr();
      check("R6 flag cleared", 32'(int_flags), 0);
      do_wr(16'hDEAD);
      check("R7 write past count no event", 32'(int_flags), 0);

      // R4 wrong-direction write in read mode is ignored; R3 readback
      do_cmd(8'h41, 10);
      do_wr(16'hBEEF);
      do_rd(16'h1100, "R4 read word0"); do_rd(16'h3322, "R3 read word1");
      do_rd(16'h5544, "R3 read word2"); do_rd(16'h7766, "R3 read word3");
      do_rd(16'h9988, "R3 read word4");
      check("R9 async empty after read", 32'(async_full), 0);
      check("R7 read after count", 32'(rd_data), 0);
      do_clr();

      // R1 unknown code mid-transfer is ignored
      do_cmd(8'hC1, 6);
      do_wr(16'hA0A1);
      do_cmd(8'h55, 2);
      do_wr(16'hB0B1);
      check("R1 no early event", 32'(int_flags), 0);
      do_wr(16'hC0C1);
      check("R1 event after third word", 32'(int_flags), 32'h04);
      do_clr();
      do_cmd(8'h41, 6);
      do_rd(16'hA0A1, "R1 word0"); do_rd(16'hB0B1, "R1 word1"); do_rd(16'hC0C1, "R1 word2");
      do_clr();

      // R8 odd count on iso half 0
      do_cmd(8'hC0, 6);
      do_wr(16'hAAAA); do_wr(16'hBBBB); do_wr(16'hCCCC);
      check("R9 iso half0 full", 32'(iso_full), 32'h1);
      do_clr();
      do_cmd(8'h40, 6);
      do_rd(16'hAAAA, "R3 iso word0"); do_rd(16'hBBBB, "R3 iso word1"); do_rd(16'hCCCC, "R3 iso word2");
      check("R9 iso half0 empty", 32'(iso_full), 0);
      do_clr();
      do_cmd(8'hC0, 5);
      do_wr(16'h1111); do_wr(16'h2222);
      check("R8 no event after two words", 32'(int_flags), 0);
      do_wr(16'h3333);
      check("R8 event after rounded count", 32'(int_flags), 32'h04);
      do_clr();
      do_cmd(8'h40, 6);
      do_rd(16'h1111, "R8 word0"); do_rd(16'h2222, "R8 word1");
      do_rd(16'hCC33, "R8 high byte kept old value");
      do_clr();

      // R7 zero count
      do_cmd(8'hC1, 0);
      do_wr(16'h1234);
      check("R7 zero count no event", 32'(int_flags), 0);
      check("R7 zero count async not full", 32'(async_full), 0);
      do_cmd(8'h41, 0);
      check("R7 zero count read", 32'(rd_data), 0);

      // R12 count above depth clamps to depth
      do_cmd(8'hC1, 300);
      for (int i = 0; i < DEPTH / 2 - 1; i++) do_wr(16'(16'h0100 + i));
      check("R12 no event before depth", 32'(int_flags), 0);
      do_wr(16'hFFEE);
      check("R12 event at depth", 32'(int_flags), 32'h04);
      do_clr();
      do_cmd(8'h41, 2);
      do_rd(16'h0100, "R12 word0");
      do_clr();

      // R10 ping-pong halves
      do_sof();
      check("R10 swap to half1", 32'(iso_half), 1);
      do_sof();
      check("R10 swap to half0", 32'(iso_half), 0);
      do_cmd(8'hC0, 2); do_wr(16'h5A5A);
      check("R9 half0 full", 32'(iso_full), 32'h1);
      do_sof();
      check("R10 swap with one full", 32'(iso_half), 1);
      do_cmd(8'hC0, 2); do_wr(16'hA5A5);
      check("R9 both full", 32'(iso_full), 32'h3);
      do_sof();
      check("R10 hold on half1", 32'(iso_half), 1);
      do_cmd(8'h40, 2);
      do_rd(16'hA5A5, "R10 half1 data");
      check("R9 half1 emptied", 32'(iso_full), 32'h1);
      do_sof();
      check("R10 swap back to half0", 32'(iso_half), 0);
      do_cmd(8'h40, 2);
      do_rd(16'h5A5A, "R10 half0 data");
      check("R9 half0 emptied", 32'(iso_full), 0);
      do_cmd(8'hC0, 2); do_wr(16'h0F0F);
      check("R9 half0 full again", 32'(iso_full), 32'h1);
      ctl_release = 3'b001;
      @(negedge clk);
      ctl_release = '0;
      check("R9 release clears half0", 32'(iso_full), 0);
      do_clr();

      repeat (3) @(negedge clk);
      check("R3 scoreboard drained", 32'(exp_q.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule